// File: doc/BRIEF.md
# Partitioned Message Buffer Allocator

This block keeps the busy flags for a fixed pool of message buffer slots. Two clients draw slots from it: a receive path and a transmit path. Each client raises a request and, in the same cycle, sees either a grant with the index of the slot it now owns or a fail. The slot is marked busy at the clock edge that ends that cycle. A separate free port returns one slot per cycle to the pool. The buffer memory and any queue of owned slots sit outside the block. Only indices and flags are managed here.

The pool is split into two regions. The lowest quarter is reserved for receive buffers. The transmit path may only take slots from the upper three quarters. A backlog of outgoing messages therefore cannot use up the buffers that incoming replies need.

Two count outputs report how many slots are free in each region. The host side uses them to decide whether to throttle.

Top module: `buf_slot_alloc`

## Requirements
- R1: A transmit request takes the lowest-indexed free slot among indices POOL_SIZE/4 to POOL_SIZE-1. It never takes a slot below POOL_SIZE/4, even when those slots are free.
- R2: A receive request takes the lowest-indexed free slot over the whole pool, starting at index 0.
- R3: Grant and index are valid combinationally in the cycle of the request. The granted slot reads busy from the next clock edge on, so it is not granted again until it is freed.
- R4: When no eligible slot is free, the requester sees its fail output high and its grant low, and the pool state does not change.
- R5: A free request with index freeIdx clears only that slot's busy flag. Freeing a slot that is already free has no effect.
- R6: When receive and transmit request in the same cycle, receive is served first. Transmit gets the lowest eligible free slot other than the one granted to receive, or fails if there is none.
- R7: A free and an allocation in the same cycle are resolved free first, so the slot being freed may be granted in that same cycle.
- R8: freeLow reports the number of free slots below POOL_SIZE/4 and freeHigh the number of free slots at or above it, both taken from the state after the last clock edge.
- R9: After reset every slot is free, so freeLow = POOL_SIZE/4 and freeHigh = 3*POOL_SIZE/4. Grant and fail outputs are low while no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rxReq | input | 1 | Receive allocation request |
| txReq | input | 1 | Transmit allocation request |
| freeReq | input | 1 | Free request |
| freeIdx | input | $clog2(POOL_SIZE) | Index of the slot to free |
| rxGrant | output | 1 | Receive request granted |
| rxFail | output | 1 | Receive request found no free slot |
| rxIdx | output | $clog2(POOL_SIZE) | Slot granted to receive |
| txGrant | output | 1 | Transmit request granted |
| txFail | output | 1 | Transmit request found no free upper slot |
| txIdx | output | $clog2(POOL_SIZE) | Slot granted to transmit |
| freeLow | output | $clog2(POOL_SIZE+1) | Free slots in the reserved lower quarter |
| freeHigh | output | $clog2(POOL_SIZE+1) | Free slots in the upper region |

## Verification
The bench uses an 8-slot pool. Directed sequences come first:
- Transmit-only fills show that the reserved quarter is never reached, and that transmit fails while lower slots remain free.
- Receive-only fills show that the search starts at zero.
- Paired requests against one or two remaining slots separate the receive-first rule from a shared search.
- Free-and-allocate on the same slot shows the free-first ordering.

A long pseudo-random sweep then drives every combination of the three request inputs and all free indices. An arithmetic pool model predicts every grant, index, fail and count, and the bench compares against it in each cycle.

// File: rtl/slot_alloc_pkg.sv
package slot_alloc_pkg;
  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic setRx;     // mark receive slot busy
    logic setTx;     // mark transmit slot busy
    logic txUseAlt;  // transmit takes the search that skips the receive slot
    logic clrFree;   // clear the slot named by freeIdx
  } allocStrobe_t;
endpackage

// File: rtl/slot_prio_enc.sv
module slot_prio_enc #(
  parameter int W = 64,
  localparam int IW = $clog2(W)
) (
  input  logic [W-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/slot_alloc_ctrl.sv
module slot_alloc_ctrl
  import slot_alloc_pkg::*;
(
  input  logic         rxReq,
  input  logic         txReq,
  input  logic         freeReq,
  input  logic         rxFound,
  input  logic         txFound,
  input  logic         txAltFound,
  output allocStrobe_t strb,
  output logic         rxGrant,
  output logic         rxFail,
  output logic         txGrant,
  output logic         txFail
);
  logic txOk;

  always_comb begin
    strb          = '0;
    strb.setRx    = rxReq && rxFound;
    strb.txUseAlt = strb.setRx;
    txOk          = strb.txUseAlt ? txAltFound : txFound;
    strb.setTx    = txReq && txOk;
    strb.clrFree  = freeReq;
    rxGrant       = strb.setRx;
    rxFail        = rxReq && !rxFound;
    txGrant       = strb.setTx;
    txFail        = txReq && !txOk;
  end
endmodule

// File: rtl/slot_alloc_dpath.sv
module slot_alloc_dpath
  import slot_alloc_pkg::*;
#(
  parameter int POOL_SIZE = 64,
  localparam int IW = $clog2(POOL_SIZE),
  localparam int CW = $clog2(POOL_SIZE + 1),
  localparam int QUARTER = POOL_SIZE / 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  allocStrobe_t  strb,
  input  logic [IW-1:0] freeIdx,
  output logic          rxFound,
  output logic          txFound,
  output logic          txAltFound,
  output logic [IW-1:0] rxIdx,
  output logic [IW-1:0] txIdx,
  output logic [CW-1:0] freeLow,
  output logic [CW-1:0] freeHigh
);
  logic [POOL_SIZE-1:0] busyQ, busyD;
  logic [POOL_SIZE-1:0] freeMask, availEff, upperMask, rxHot, txHot;
  logic [IW-1:0]        txPrimIdx, txAltIdx;

  always_comb begin
    for (int i = 0; i < POOL_SIZE; i++) begin
      freeMask[i]  = strb.clrFree && (freeIdx == IW'(i));
      upperMask[i] = (i >= QUARTER);
    end
    availEff = ~busyQ | freeMask;
  end

  slot_prio_enc #(.W(POOL_SIZE)) uRxEnc (
    .vec(availEff), .found(rxFound), .idx(rxIdx));

  slot_prio_enc #(.W(POOL_SIZE)) uTxEnc (
    .vec(availEff & upperMask), .found(txFound), .idx(txPrimIdx));

  slot_prio_enc #(.W(POOL_SIZE)) uTxAltEnc (
    .vec(availEff & upperMask & ~rxHot), .found(txAltFound), .idx(txAltIdx));

  always_comb begin
    for (int i = 0; i < POOL_SIZE; i++) begin
      rxHot[i] = rxFound && (rxIdx == IW'(i));
    end
    txIdx = strb.txUseAlt ? txAltIdx : txPrimIdx;
    for (int i = 0; i < POOL_SIZE; i++) begin
      txHot[i] = strb.setTx && (txIdx == IW'(i));
    end
    busyD = busyQ & ~freeMask;
    if (strb.setRx) busyD = busyD | rxHot;
    busyD = busyD | txHot;
  end

  always_ff @(posedge clk) begin
    if (!rstN) busyQ <= '0;
    else       busyQ <= busyD;
  end

  always_comb begin
    freeLow  = '0;
    freeHigh = '0;
    for (int i = 0; i < POOL_SIZE; i++) begin
      if (!busyQ[i]) begin
        if (i < QUARTER) freeLow  = freeLow + CW'(1);
        else             freeHigh = freeHigh + CW'(1);
      end
    end
  end

  AST_TX_UPPER_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    strb.setTx |-> (int'(txIdx) >= QUARTER)); // R1

  AST_GRANT_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strb.setRx |=> busyQ[$past(rxIdx)]); // R3

  AST_IDLE_HOLDS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.setRx && !strb.setTx && !strb.clrFree) |=> $stable(busyQ)); // R4

  AST_FREE_CLEARS_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.clrFree && !(strb.setRx && rxIdx == freeIdx) && !(strb.setTx && txIdx == freeIdx))
      |=> !busyQ[$past(freeIdx)]); // R5

  AST_PAIR_DISTINCT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.setRx && strb.setTx) |-> (rxIdx != txIdx)); // R6

  AST_GRANT_WAS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    strb.setTx |-> (!busyQ[txIdx] || (strb.clrFree && freeIdx == txIdx))); // R7
endmodule

// File: rtl/buf_slot_alloc.sv
module buf_slot_alloc
  import slot_alloc_pkg::*;
#(
  parameter int POOL_SIZE = 64,
  localparam int IW = $clog2(POOL_SIZE),
  localparam int CW = $clog2(POOL_SIZE + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          rxReq,
  input  logic          txReq,
  input  logic          freeReq,
  input  logic [IW-1:0] freeIdx,
  output logic          rxGrant,
  output logic          rxFail,
  output logic [IW-1:0] rxIdx,
  output logic          txGrant,
  output logic          txFail,
  output logic [IW-1:0] txIdx,
  output logic [CW-1:0] freeLow,
  output logic [CW-1:0] freeHigh
);
  initial begin
    if (POOL_SIZE % 4 != 0 || POOL_SIZE < 4)
      $error("POOL_SIZE must be a positive multiple of 4");
  end

  allocStrobe_t strb;
  logic rxFound, txFound, txAltFound;

  slot_alloc_ctrl uCtrl (
    .rxReq(rxReq), .txReq(txReq), .freeReq(freeReq),
    .rxFound(rxFound), .txFound(txFound), .txAltFound(txAltFound),
    .strb(strb), .rxGrant(rxGrant), .rxFail(rxFail),
    .txGrant(txGrant), .txFail(txFail));

  slot_alloc_dpath #(.POOL_SIZE(POOL_SIZE)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .freeIdx(freeIdx),
    .rxFound(rxFound), .txFound(txFound), .txAltFound(txAltFound),
    .rxIdx(rxIdx), .txIdx(txIdx), .freeLow(freeLow), .freeHigh(freeHigh));
endmodule

// File: tb/sim_buf_slot_alloc.sv
module sim_buf_slot_alloc;
  localparam int N  = 8;
  localparam int Q  = N / 4;
  localparam int IW = $clog2(N);
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0;
  logic rstN;
  logic rxReq, txReq, freeReq;
  logic [IW-1:0] freeIdx;
  logic rxGrant, rxFail, txGrant, txFail;
  logic [IW-1:0] rxIdx, txIdx;
  logic [CW-1:0] freeLow, freeHigh;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mb [N];

  always #5 clk = ~clk;

  buf_slot_alloc #(.POOL_SIZE(N)) u0 (
    .clk(clk), .rstN(rstN), .rxReq(rxReq), .txReq(txReq),
    .freeReq(freeReq), .freeIdx(freeIdx), .rxGrant(rxGrant), .rxFail(rxFail),
    .rxIdx(rxIdx), .txGrant(txGrant), .txFail(txFail), .txIdx(txIdx),
    .freeLow(freeLow), .freeHigh(freeHigh));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // one request cycle: drive at negedge, check the combinational result,
  // then advance the model at the clock edge
  task automatic step(input bit r, input bit t, input bit f, input int fi, input string tag);
    bit avail [N];
    bit eRxG, eTxG;
    int eRxI, eTxI, lo, hi;
    rxReq = r; txReq = t; freeReq = f; freeIdx = IW'(fi);
    #1;
    eRxG = 0; eTxG = 0; eRxI = 0; eTxI = 0; lo = 0; hi = 0;
    for (int i = 0; i < N; i++) begin
      avail[i] = !mb[i] || (f && fi == i);
      if (!mb[i]) begin
        if (i < Q) lo++; else hi++;
      end
    end
    if (r) for (int i = 0; i < N; i++)
      if (avail[i] && !eRxG) begin eRxG = 1; eRxI = i; end
    if (t) for (int i = Q; i < N; i++)
      if (avail[i] && !(eRxG && i == eRxI) && !eTxG) begin eTxG = 1; eTxI = i; end
    chk({tag, " R2 rxGrant"}, int'(rxGrant), int'(eRxG));
    chk({tag, " R4 rxFail"}, int'(rxFail), int'(r && !eRxG));
    if (eRxG) chk({tag, " R2 rxIdx"}, int'(rxIdx), eRxI);
    chk({tag, " R1 txGrant"}, int'(txGrant), int'(eTxG));
    chk({tag, " R4 txFail"}, int'(txFail), int'(t && !eTxG));
    if (eTxG) chk({tag, " R1 txIdx"}, int'(txIdx), eTxI);
    chk({tag, " R8 freeLow"}, int'(freeLow), lo);
    chk({tag, " R8 freeHigh"}, int'(freeHigh), hi);
    @(posedge clk);
    if (f) mb[fi] = 0;
    if (eRxG) mb[eRxI] = 1;
    if (eTxG) mb[eTxI] = 1;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    rstN = 0; rxReq = 0; txReq = 0; freeReq = 0; freeIdx = '0;
    for (int i = 0; i < N; i++) mb[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    chk("R9 freeLow", int'(freeLow), Q);
    chk("R9 freeHigh", int'(freeHigh), N - Q);
    chk("R9 rxGrant", int'(rxGrant), 0);
    chk("R9 txFail", int'(txFail), 0);
    @(negedge clk);

    // transmit fills the upper region only
    rxReq = 0; txReq = 1; freeReq = 0; #1;
    chk("R1 first tx index", int'(txIdx), Q);
    for (int k = 0; k < N - Q; k++) step(0, 1, 0, 0, "R1 tx fill");
    txReq = 1; #1;
    chk("R1 tx fails with lower free", int'(txFail), 1);
    step(0, 1, 0, 0, "R4 tx full");
    chk("R4 lower untouched", int'(freeLow), Q);

    // receive takes the reserved quarter from index 0
    rxReq = 1; txReq = 0; #1;
    chk("R2 rx starts at 0", int'(rxIdx), 0);
    for (int k = 0; k < Q; k++) step(1, 0, 0, 0, "R2 rx fill");
    step(1, 1, 0, 0, "R4 both full");
    chk("R4 state kept low", int'(freeLow), 0);
    chk("R4 state kept high", int'(freeHigh), 0);

    // free and reuse
    step(0, 0, 1, 5, "R5 free");
    chk("R5 one slot freed", int'(freeHigh), 1);
    step(0, 0, 1, 5, "R5 double free");
    chk("R5 double free no effect", int'(freeHigh), 1);
    txReq = 1; #1;
    chk("R5 tx reuses 5", int'(txIdx), 5);
    step(0, 1, 0, 0, "R5 realloc");

    // simultaneous requests
    step(0, 0, 1, 3, "R6 prep");
    step(0, 0, 1, 6, "R6 prep");
    rxReq = 1; txReq = 1; #1;
    chk("R6 rx takes 3", int'(rxIdx), 3);
    chk("R6 tx takes 6", int'(txIdx), 6);
    step(1, 1, 0, 0, "R6 pair");
    step(0, 0, 1, 4, "R6 prep");
    rxReq = 1; txReq = 1; #1;
    chk("R6 rx wins last slot", int'(rxIdx), 4);
    chk("R6 tx fails", int'(txFail), 1);
    step(1, 1, 0, 0, "R6 contend");

    // free first ordering
    rxReq = 0; txReq = 1; freeReq = 1; freeIdx = IW'(7); #1;
    chk("R7 tx gets freed 7", int'(txGrant) * 16 + int'(txIdx), 16 + 7);
    step(0, 1, 1, 7, "R7 tx");
    rxReq = 1; txReq = 0; freeReq = 1; freeIdx = IW'(1); #1;
    chk("R7 rx gets freed 1", int'(rxGrant) * 16 + int'(rxIdx), 16 + 1);
    step(1, 0, 1, 1, "R7 rx");

    // pseudo-random sweep
    lfsr = 16'hACE1;
    for (int k = 0; k < 2000; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[4], lfsr[1] & lfsr[5], lfsr[2] | lfsr[6], int'(lfsr[9:7]), "R3 sweep");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule